// File: doc/BRIEF.md
# Privileged Return and Trap-Check Unit

This unit sits beside the decode stage of a RISC-V hart. It handles the four privileged instructions that change control state or need gating: MRET, SRET, WFI and SFENCE.VMA. Decode presents a one-hot strobe for the instruction together with the current privilege mode, the machine status word, and both exception return addresses. The unit then gives exactly one of two results. The first is an illegal-instruction exception request. The second is, for a legal trap return, a PC redirect, a new privilege mode, a rewritten status word with its write enable, and a return-from-trap pulse.

Every result is registered and stands for one cycle, the cycle after the strobe. WFI and SFENCE.VMA are only checked for legality here. Sleeping and translation flushing belong to other blocks. A single input states whether user mode is implemented. This input chooses the privilege that a trap return writes back into the previous-privilege field.

Top module: `priv_ret_unit`

## Requirements
- R1: While reset is held and in the first cycle after it, `redirect_valid`, `mstatus_we`, `exc_valid` and `xret_pulse` are all 0.
- R2: MRET with `cur_priv` other than machine (3) raises `exc_valid` with `exc_cause` = 2 and `exc_tval` = 0. `redirect_valid`, `mstatus_we` and `xret_pulse` all stay 0.
- R3: SRET raises the illegal-instruction exception (cause 2) in user mode (0). It also raises it in supervisor mode (1) when status bit 22 (trap-return gate) is 1. In machine mode SRET is legal whatever bit 22 holds.
- R4: A legal MRET sets `redirect_valid` with `redirect_pc` = `mepc_i`. `next_priv` takes the value of status bits 12:11 as they were before the update.
- R5: On a legal MRET, `mstatus_o` copies bit 7 into bit 3 and sets bit 7 to 1. Bits 12:11 become 0 when `umode_present` is 1 and 3 when it is 0. Every other bit passes through, and `mstatus_we` is 1.
- R6: A legal SRET sets `redirect_valid` with `redirect_pc` = `sepc_i`. `next_priv` is 1 if status bit 8 was 1 and 0 otherwise. `mstatus_o` copies bit 5 into bit 1 and sets bit 5 to 1. Bit 8 becomes 0 when `umode_present` is 1 and 1 when it is 0. Every other bit passes through, and `mstatus_we` is 1.
- R7: SFENCE.VMA raises the illegal-instruction exception (cause 2) in user mode. It also raises it in supervisor mode when status bit 20 (translation gate) is 1. Otherwise it produces no active output.
- R8: WFI never raises an exception and produces no active output in any mode, whatever the status word holds.
- R9: `xret_pulse` is 1 for exactly the one cycle after a legal MRET or SRET and is 0 after an illegal one.
- R10: Outputs appear in the cycle after the strobe and last one cycle. Strobes in consecutive cycles give results in consecutive cycles. Strobe bit 0 is MRET, bit 1 is SRET, bit 2 is WFI and bit 3 is SFENCE.VMA. A cycle with no strobe bit set is followed by a cycle with no active output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_strobe | input | 4 | One-hot decoded instruction: 0 MRET, 1 SRET, 2 WFI, 3 SFENCE.VMA |
| cur_priv | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| mstatus_i | input | XLEN | Current machine status word |
| mepc_i | input | XLEN | Machine exception return address |
| sepc_i | input | XLEN | Supervisor exception return address |
| umode_present | input | 1 | 1 when user mode is implemented |
| redirect_valid | output | 1 | Take the PC redirect this cycle |
| redirect_pc | output | XLEN | Redirect target |
| next_priv | output | 2 | Privilege after the return, meaningful with redirect_valid |
| mstatus_o | output | XLEN | Updated status word |
| mstatus_we | output | 1 | Write enable for mstatus_o |
| exc_valid | output | 1 | Illegal-instruction exception request |
| exc_cause | output | CAUSE_W | Exception cause code (2) |
| exc_tval | output | XLEN | Trap value, always 0 |
| xret_pulse | output | 1 | One-cycle return-from-trap indication |

## Verification
The legality gate and the status stacking act on the same instruction in the same cycle. An SRET issued in supervisor mode with the trap-return gate set, and an MRET from a lower mode, are both presented with status words that would give a distinct stacked result. The bench requires the exception alone, with no write enable, redirect or pulse. It also issues an MRET and an SRET on back-to-back cycles. The first result must stand one cycle and then give way to the second. Neither may carry the other's status fields.

// File: rtl/priv_ret_pkg.sv
package priv_ret_pkg;
  localparam int OP_N      = 4;
  localparam int OP_MRET   = 0;
  localparam int OP_SRET   = 1;
  localparam int OP_WFI    = 2;
  localparam int OP_SFENCE = 3;

  localparam logic [1:0] PRV_U = 2'd0;
  localparam logic [1:0] PRV_S = 2'd1;
  localparam logic [1:0] PRV_M = 2'd3;

  localparam int ST_SIE    = 1;
  localparam int ST_MIE    = 3;
  localparam int ST_SPIE   = 5;
  localparam int ST_MPIE   = 7;
  localparam int ST_SPP    = 8;
  localparam int ST_MPP_LO = 11;
  localparam int ST_MPP_HI = 12;
  localparam int ST_TVM    = 20;
  localparam int ST_TSR    = 22;

  localparam int CAUSE_ILLEGAL = 2;
endpackage

// File: rtl/priv_legal_check.sv
module priv_legal_check
  import priv_ret_pkg::*;
(
  input  logic [OP_N-1:0] op,
  input  logic [1:0]      priv,
  input  logic            tsr,
  input  logic            tvm,
  output logic            mret_ok,
  output logic            sret_ok,
  output logic            illegal
);
  logic in_m, in_s, in_u;
  logic mret_bad, sret_bad, sfence_bad;

  always_comb begin
    in_m = (priv == PRV_M);
    in_s = (priv == PRV_S);
    in_u = (priv == PRV_U);
    mret_bad   = op[OP_MRET] && !in_m;
    sret_bad   = op[OP_SRET] && (in_u || (in_s && tsr));
    sfence_bad = op[OP_SFENCE] && (in_u || (in_s && tvm));
    mret_ok    = op[OP_MRET] && !mret_bad;
    sret_ok    = op[OP_SRET] && !sret_bad;
    illegal    = mret_bad || sret_bad || sfence_bad;
  end
endmodule

// File: rtl/xret_stack.sv
module xret_stack
  import priv_ret_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter bit IS_MACHINE = 1'b1
) (
  input  logic [XLEN-1:0] status_in,
  input  logic            umode,
  output logic [XLEN-1:0] status_out,
  output logic [1:0]      target
);
  generate
    if (IS_MACHINE) begin : g_mach
      always_comb begin
        status_out                      = status_in;
        status_out[ST_MIE]              = status_in[ST_MPIE];
        status_out[ST_MPIE]             = 1'b1;
        status_out[ST_MPP_HI:ST_MPP_LO] = umode ? PRV_U : PRV_M;
        target                          = status_in[ST_MPP_HI:ST_MPP_LO];
      end
    end else begin : g_sup
      always_comb begin
        status_out          = status_in;
        status_out[ST_SIE]  = status_in[ST_SPIE];
        status_out[ST_SPIE] = 1'b1;
        status_out[ST_SPP]  = umode ? PRV_U[0] : PRV_M[0];
        target              = status_in[ST_SPP] ? PRV_S : PRV_U;
      end
    end
  endgenerate
endmodule

// File: rtl/priv_ret_unit.sv
module priv_ret_unit
  import priv_ret_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int CAUSE_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [OP_N-1:0]    op_strobe,
  input  logic [1:0]         cur_priv,
  input  logic [XLEN-1:0]    mstatus_i,
  input  logic [XLEN-1:0]    mepc_i,
  input  logic [XLEN-1:0]    sepc_i,
  input  logic               umode_present,
  output logic               redirect_valid,
  output logic [XLEN-1:0]    redirect_pc,
  output logic [1:0]         next_priv,
  output logic [XLEN-1:0]    mstatus_o,
  output logic               mstatus_we,
  output logic               exc_valid,
  output logic [CAUSE_W-1:0] exc_cause,
  output logic [XLEN-1:0]    exc_tval,
  output logic               xret_pulse
);
  logic            mret_ok, sret_ok, illegal, any_op, ret_ok;
  logic [XLEN-1:0] m_status, s_status;
  logic [1:0]      m_target, s_target;

  logic            ret_d, exc_d;
  logic [XLEN-1:0] pc_d, st_d;
  logic [1:0]      priv_d;

  logic            ret_q, exc_q;
  logic [XLEN-1:0] pc_q, st_q;
  logic [1:0]      priv_q;

  priv_legal_check u_legal (
    .op      (op_strobe),
    .priv    (cur_priv),
    .tsr     (mstatus_i[ST_TSR]),
    .tvm     (mstatus_i[ST_TVM]),
    .mret_ok (mret_ok),
    .sret_ok (sret_ok),
    .illegal (illegal)
  );

  xret_stack #(.XLEN(XLEN), .IS_MACHINE(1'b1)) u_mstack (
    .status_in  (mstatus_i),
    .umode      (umode_present),
    .status_out (m_status),
    .target     (m_target)
  );

  xret_stack #(.XLEN(XLEN), .IS_MACHINE(1'b0)) u_sstack (
    .status_in  (mstatus_i),
    .umode      (umode_present),
    .status_out (s_status),
    .target     (s_target)
  );

  always_comb begin
    any_op = |op_strobe;
    ret_ok = mret_ok || sret_ok;
    ret_d  = ret_ok;
    exc_d  = illegal;
    pc_d   = mret_ok ? mepc_i   : sepc_i;
    st_d   = mret_ok ? m_status : s_status;
    priv_d = mret_ok ? m_target : (sret_ok ? s_target : cur_priv);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ret_q <= 1'b0;
      exc_q <= 1'b0;
    end else begin
      ret_q <= ret_d;
      exc_q <= exc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q   <= '0;
      st_q   <= '0;
      priv_q <= PRV_M;
    end else if (any_op) begin
      pc_q   <= pc_d;
      st_q   <= st_d;
      priv_q <= priv_d;
    end
  end

  assign redirect_valid = ret_q;
  assign redirect_pc    = pc_q;
  assign next_priv      = priv_q;
  assign mstatus_o      = st_q;
  assign mstatus_we     = ret_q;
  assign xret_pulse     = ret_q;
  assign exc_valid      = exc_q;
  assign exc_cause      = CAUSE_W'(CAUSE_ILLEGAL);
  assign exc_tval       = '0;
endmodule

// File: rtl/priv_ret_chk.sv
module priv_ret_chk
  import priv_ret_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int CAUSE_W = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [OP_N-1:0]    op_strobe,
  input logic [1:0]         cur_priv,
  input logic [XLEN-1:0]    mstatus_i,
  input logic [XLEN-1:0]    mepc_i,
  input logic               redirect_valid,
  input logic [XLEN-1:0]    redirect_pc,
  input logic [1:0]         next_priv,
  input logic [XLEN-1:0]    mstatus_o,
  input logic               mstatus_we,
  input logic               exc_valid,
  input logic [CAUSE_W-1:0] exc_cause,
  input logic               xret_pulse
);
  AST_EXC_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> (!redirect_valid && !mstatus_we && !xret_pulse && exc_cause == CAUSE_W'(CAUSE_ILLEGAL))); // R2
  AST_MRET_LOW_PRIV: assert property (@(posedge clk) disable iff (!rst_n)
    $past(op_strobe[OP_MRET] && cur_priv != PRV_M) |-> (exc_valid && !redirect_valid)); // R2
  AST_SRET_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $past(op_strobe[OP_SRET] && cur_priv == PRV_S && mstatus_i[ST_TSR]) |-> (exc_valid && !xret_pulse)); // R3
  AST_MRET_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(op_strobe[OP_MRET] && cur_priv == PRV_M) |->
      (redirect_valid && redirect_pc == $past(mepc_i) && next_priv == $past(mstatus_i[ST_MPP_HI:ST_MPP_LO]))); // R4
  AST_MRET_STACK: assert property (@(posedge clk) disable iff (!rst_n)
    $past(op_strobe[OP_MRET] && cur_priv == PRV_M) |->
      (mstatus_o[ST_MPIE] && mstatus_o[ST_MIE] == $past(mstatus_i[ST_MPIE]))); // R5
  AST_SFENCE_USER: assert property (@(posedge clk) disable iff (!rst_n)
    $past(op_strobe[OP_SFENCE] && cur_priv == PRV_U) |-> exc_valid); // R7
  AST_WFI_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(op_strobe[OP_WFI]) |-> (!exc_valid && !redirect_valid)); // R8
  AST_PULSE_NEEDS_RET: assert property (@(posedge clk) disable iff (!rst_n)
    xret_pulse |-> $past(op_strobe[OP_MRET] || op_strobe[OP_SRET])); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(op_strobe == '0) |-> (!redirect_valid && !mstatus_we && !exc_valid && !xret_pulse)); // R10
endmodule

bind priv_ret_unit priv_ret_chk #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .op_strobe      (op_strobe),
  .cur_priv       (cur_priv),
  .mstatus_i      (mstatus_i),
  .mepc_i         (mepc_i),
  .redirect_valid (redirect_valid),
  .redirect_pc    (redirect_pc),
  .next_priv      (next_priv),
  .mstatus_o      (mstatus_o),
  .mstatus_we     (mstatus_we),
  .exc_valid      (exc_valid),
  .exc_cause      (exc_cause),
  .xret_pulse     (xret_pulse)
);

// File: tb/priv_ret_unit_tb_top.sv
module priv_ret_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN       = 32;
  localparam int CAUSE_W    = 4;

  localparam logic [3:0] S_MRET = 4'b0001;
  localparam logic [3:0] S_SRET = 4'b0010;
  localparam logic [3:0] S_WFI  = 4'b0100;
  localparam logic [3:0] S_SFV  = 4'b1000;

  logic clk = 1'b0;
  logic rst_n;
  logic [3:0]         op_strobe;
  logic [1:0]         cur_priv;
  logic [XLEN-1:0]    mstatus_i, mepc_i, sepc_i;
  logic               umode_present;
  logic               redirect_valid, mstatus_we, exc_valid, xret_pulse;
  logic [XLEN-1:0]    redirect_pc, mstatus_o, exc_tval;
  logic [1:0]         next_priv;
  logic [CAUSE_W-1:0] exc_cause;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  priv_ret_unit #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .op_strobe(op_strobe), .cur_priv(cur_priv),
    .mstatus_i(mstatus_i), .mepc_i(mepc_i), .sepc_i(sepc_i),
    .umode_present(umode_present), .redirect_valid(redirect_valid),
    .redirect_pc(redirect_pc), .next_priv(next_priv), .mstatus_o(mstatus_o),
    .mstatus_we(mstatus_we), .exc_valid(exc_valid), .exc_cause(exc_cause),
    .exc_tval(exc_tval), .xret_pulse(xret_pulse)
  );

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [XLEN-1:0] exp_m(input logic [XLEN-1:0] ms, input logic um);
    logic [XLEN-1:0] r = ms;
    r[3] = ms[7];
    r[7] = 1'b1;
    r[12:11] = um ? 2'd0 : 2'd3;
    return r;
  endfunction

  function automatic logic [XLEN-1:0] exp_s(input logic [XLEN-1:0] ms, input logic um);
    logic [XLEN-1:0] r = ms;
    r[1] = ms[5];
    r[5] = 1'b1;
    r[8] = um ? 1'b0 : 1'b1;
    return r;
  endfunction

  task automatic drive(input logic [3:0] op, input logic [1:0] pv, input logic [XLEN-1:0] ms,
                       input logic [XLEN-1:0] me, input logic [XLEN-1:0] se, input logic um);
    op_strobe = op; cur_priv = pv; mstatus_i = ms; mepc_i = me; sepc_i = se; umode_present = um;
  endtask

  task automatic expect_quiet(input string req, input string tag);
    chk(req, {tag, " redirect_valid"}, redirect_valid, 0);
    chk(req, {tag, " mstatus_we"}, mstatus_we, 0);
    chk(req, {tag, " exc_valid"}, exc_valid, 0);
    chk(req, {tag, " xret_pulse"}, xret_pulse, 0);
  endtask

  task automatic expect_illegal(input string req, input string tag);
    chk(req, {tag, " exc_valid"}, exc_valid, 1);
    chk(req, {tag, " exc_cause"}, exc_cause, 2);
    chk(req, {tag, " exc_tval"}, exc_tval, 0);
    chk(req, {tag, " redirect_valid"}, redirect_valid, 0);
    chk(req, {tag, " mstatus_we"}, mstatus_we, 0);
    chk(req, {tag, " xret_pulse"}, xret_pulse, 0);
  endtask

  task automatic expect_ret(input string req, input string tag, input logic [XLEN-1:0] pc,
                            input logic [1:0] pv, input logic [XLEN-1:0] st);
    chk(req, {tag, " redirect_valid"}, redirect_valid, 1);
    chk(req, {tag, " redirect_pc"}, redirect_pc, pc);
    chk(req, {tag, " next_priv"}, next_priv, pv);
    chk(req, {tag, " mstatus_o"}, mstatus_o, st);
    chk(req, {tag, " mstatus_we"}, mstatus_we, 1);
    chk(req, {tag, " exc_valid"}, exc_valid, 0);
    chk("R9", {tag, " xret_pulse"}, xret_pulse, 1);
  endtask

  // One strobe: apply at a falling edge, result is visible at the next falling edge.
  task automatic issue(input logic [3:0] op, input logic [1:0] pv, input logic [XLEN-1:0] ms,
                       input logic [XLEN-1:0] me, input logic [XLEN-1:0] se, input logic um);
    @(negedge clk);
    drive(op, pv, ms, me, se, um);
    @(negedge clk);
    op_strobe = '0;
  endtask

  task automatic then_idle(input string tag);
    @(negedge clk);
    expect_quiet("R10", {tag, " following cycle"});
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    drive('0, 2'd3, '0, '0, '0, 1'b1);
    repeat (3) @(negedge clk);
    expect_quiet("R1", "in reset");
    rst_n = 1'b1;
    @(negedge clk);
    expect_quiet("R1", "after reset");
  endtask

  task automatic t_mret_illegal;
    issue(S_MRET, 2'd1, 32'h0000_1888, 32'h8000_0000, 32'h0, 1'b1);
    expect_illegal("R2", "mret from S");
    issue(S_MRET, 2'd0, 32'h0000_0080, 32'h8000_0000, 32'h0, 1'b1);
    expect_illegal("R2", "mret from U");
    then_idle("mret illegal");
  endtask

  task automatic t_mret_legal;
    logic [XLEN-1:0] ms = 32'hA5A0_0880;
    issue(S_MRET, 2'd3, ms, 32'h8000_1234, 32'h4444_0000, 1'b1);
    expect_ret("R4", "mret S target", 32'h8000_1234, 2'd1, exp_m(ms, 1'b1));
    then_idle("mret legal");
    ms = 32'h0000_1808;
    issue(S_MRET, 2'd3, ms, 32'h0000_0100, 32'h0, 1'b0);
    expect_ret("R5", "mret no umode", 32'h0000_0100, 2'd3, exp_m(ms, 1'b0));
    chk("R5", "mie cleared", mstatus_o[3], 0);
    chk("R5", "mpp machine", mstatus_o[12:11], 3);
  endtask

  task automatic t_sret;
    logic [XLEN-1:0] ms;
    issue(S_SRET, 2'd0, 32'h0000_0120, 32'h0, 32'h2000, 1'b1);
    expect_illegal("R3", "sret from U");
    issue(S_SRET, 2'd1, 32'h0040_0120, 32'h0, 32'h2000, 1'b1);
    expect_illegal("R3", "sret from S with gate");
    ms = 32'h0040_0120;
    issue(S_SRET, 2'd3, ms, 32'h0, 32'h0000_2000, 1'b1);
    expect_ret("R3", "sret from M with gate", 32'h0000_2000, 2'd1, exp_s(ms, 1'b1));
    ms = 32'h0000_0002;
    issue(S_SRET, 2'd1, ms, 32'h0, 32'h0000_3000, 1'b0);
    expect_ret("R6", "sret to U no umode", 32'h0000_3000, 2'd0, exp_s(ms, 1'b0));
    chk("R6", "spp set", mstatus_o[8], 1);
    chk("R6", "sie cleared", mstatus_o[1], 0);
    then_idle("sret");
  endtask

  task automatic t_sfence;
    issue(S_SFV, 2'd0, 32'h0, 32'h0, 32'h0, 1'b1);
    expect_illegal("R7", "sfence from U");
    issue(S_SFV, 2'd1, 32'h0010_0000, 32'h0, 32'h0, 1'b1);
    expect_illegal("R7", "sfence from S with gate");
    issue(S_SFV, 2'd1, 32'h0040_0000, 32'h0, 32'h0, 1'b1);
    expect_quiet("R7", "sfence from S no gate");
    issue(S_SFV, 2'd3, 32'h0010_0000, 32'h0, 32'h0, 1'b1);
    expect_quiet("R7", "sfence from M with gate");
  endtask

  task automatic t_wfi;
    issue(S_WFI, 2'd0, 32'hFFFF_FFFF, 32'h1, 32'h2, 1'b1);
    expect_quiet("R8", "wfi from U");
    issue(S_WFI, 2'd1, 32'h0050_0000, 32'h1, 32'h2, 1'b0);
    expect_quiet("R8", "wfi from S gates set");
  endtask

  task automatic t_back_to_back;
    logic [XLEN-1:0] ms = 32'h0000_1900;
    @(negedge clk);
    drive(S_MRET, 2'd3, ms, 32'h0000_AAA0, 32'h0000_BBB0, 1'b1);
    @(negedge clk);
    drive(S_SRET, 2'd3, ms, 32'h0000_AAA0, 32'h0000_BBB0, 1'b1);
    expect_ret("R10", "first of pair", 32'h0000_AAA0, 2'd3, exp_m(ms, 1'b1));
    @(negedge clk);
    op_strobe = '0;
    expect_ret("R10", "second of pair", 32'h0000_BBB0, 2'd1, exp_s(ms, 1'b1));
    then_idle("pair");
  endtask

  initial begin
    t_reset();
    t_mret_illegal();
    t_mret_legal();
    t_sret();
    t_sfence();
    t_wfi();
    t_back_to_back();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule